// File: doc/BRIEF.md
# Program Counter with Circular Return Stack

This block holds the 13-bit instruction fetch address of a small 8-bit core and keeps the return addresses for subroutine calls and interrupts in an eight-entry circular stack. Each cycle the surrounding control logic may ask for a sequential step, a load of the low address byte from a data value, a jump or call to an 11-bit target taken from the opcode, an interrupt vector, or a return. A 5-bit high-address latch is written separately and supplies the upper address bits whenever the counter is loaded from a byte or from an opcode target.

The block presents the full address and a 10-bit wrapped address for a 1K-word program memory. It raises a one-cycle flush indication after every cycle that redirected the counter, so that the instruction already fetched from the old path is discarded. The stack reports neither overflow nor underflow, and its pointer cannot be read or written: a ninth push overwrites the oldest entry and pops keep wrapping round the ring.

Top module: `pcs_counter`

## Requirements
- R1: While reset is asserted and in the first cycles after its release, fetch_addr is 0000h and flush is 0.
- R2: With no redirect request and step_en high, fetch_addr rises by one per cycle, wrapping from 1FFFh to 0000h; with step_en low and no redirect, it holds.
- R3: lo_we loads fetch_addr with {latch[4:0], lo_din[7:0]}, using the latch value held before any write in that same cycle.
- R4: jump_req or call_req loads fetch_addr with {latch[4:3], target[10:0]}.
- R5: irq_ack loads fetch_addr with 0004h and pushes the current fetch_addr onto the stack.
- R6: call_req pushes the current fetch_addr (the address after the call); ret_req loads fetch_addr with the most recently pushed value still on the stack.
- R7: The stack is an 8-entry ring: a ninth push overwrites the first entry, and after eight pushes the ninth pop returns the same value as the first pop.
- R8: When several requests arrive together, fetch_addr follows the first of irq_ack, call_req, ret_req, jump_req, lo_we, step_en; lower ones have no effect on fetch_addr.
- R9: When a push (call_req or irq_ack) and ret_req fall in the same cycle, the pop is served first and the push then refills that slot: stack depth is unchanged, the next return yields the pushed value and the one after it the value that lay below the popped entry.
- R10: flush is 1 in exactly the cycle after any cycle with irq_ack, call_req, ret_req, jump_req or lo_we, and 0 otherwise.
- R11: mem_addr always equals fetch_addr[9:0].
- R12: The high-address latch changes only on hi_we (loaded from hi_din); pushes and pops leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_en | input | 1 | Sequential increment request |
| lo_we | input | 1 | Load low address byte from lo_din |
| lo_din | input | 8 | Data value for the low-byte load |
| hi_we | input | 1 | Write the high-address latch |
| hi_din | input | 5 | New high-address latch value |
| jump_req | input | 1 | Jump to opcode target |
| call_req | input | 1 | Call opcode target, pushing the return address |
| target | input | 11 | Opcode target field |
| irq_ack | input | 1 | Interrupt acknowledge: vector and push |
| ret_req | input | 1 | Return: pop the stack into the counter |
| fetch_addr | output | 13 | Current program counter |
| mem_addr | output | 10 | Wrapped address for the 1K-word memory |
| flush | output | 1 | Discard the already-fetched instruction |

## Verification
The interesting collision is a push and a pop in the same cycle: a call or an interrupt acknowledge arriving together with a return. The bench provokes it directly with call and return together, followed by returns that expose what remains on the ring, and again across a sweep of every combination of the seven request inputs after the ring has been filled. Each result is judged against a ring model that pops before it pushes, comparing the fetch address, the wrapped address and the flush flag in every cycle, so a lost entry, a slipped pointer or a wrong priority shows up on a later return.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  // Source chosen for the next program counter value
  typedef enum logic [2:0] {
    SEL_HOLD = 3'd0,
    SEL_INC  = 3'd1,
    SEL_LOW  = 3'd2,
    SEL_TGT  = 3'd3,
    SEL_POP  = 3'd4,
    SEL_VEC  = 3'd5
  } pc_sel_e;
endpackage

// File: rtl/pcs_next.sv
module pcs_next
  import pcs_pkg::*;
#(
  parameter int unsigned PC_W  = 13,
  parameter int unsigned LO_W  = 8,
  parameter int unsigned HI_W  = 5,
  parameter int unsigned TGT_W = 11,
  parameter logic [PC_W-1:0] VECTOR = 13'h0004
) (
  input  logic [PC_W-1:0]  pc_q,
  input  logic [HI_W-1:0]  latch_q,
  input  logic             step_en,
  input  logic             lo_we,
  input  logic [LO_W-1:0]  lo_din,
  input  logic             jump_req,
  input  logic             call_req,
  input  logic [TGT_W-1:0] target,
  input  logic             irq_ack,
  input  logic             ret_req,
  input  logic [PC_W-1:0]  pop_top,
  output logic [PC_W-1:0]  pc_nxt,
  output logic             redirect,
  output logic             push,
  output logic             pop
);
  // upper bits taken from the latch for an opcode target
  localparam int unsigned KEEP_W = PC_W - TGT_W;

  pc_sel_e sel;

  always_comb begin
    if (irq_ack)       sel = SEL_VEC;
    else if (call_req) sel = SEL_TGT;
    else if (ret_req)  sel = SEL_POP;
    else if (jump_req) sel = SEL_TGT;
    else if (lo_we)    sel = SEL_LOW;
    else if (step_en)  sel = SEL_INC;
    else               sel = SEL_HOLD;
  end

  always_comb begin
    unique case (sel)
      SEL_VEC:  pc_nxt = VECTOR;
      SEL_TGT:  pc_nxt = {latch_q[HI_W-1 -: KEEP_W], target};
      SEL_POP:  pc_nxt = pop_top;
      SEL_LOW:  pc_nxt = {latch_q, lo_din};
      SEL_INC:  pc_nxt = pc_q + 1'b1;
      default:  pc_nxt = pc_q;
    endcase
  end

  assign push     = irq_ack | call_req;
  assign pop      = ret_req;
  assign redirect = (sel != SEL_INC) && (sel != SEL_HOLD);
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int unsigned W     = 13,
  parameter int unsigned DEPTH = 8   // power of two: the pointer wraps naturally
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] top
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [PW-1:0] ptr_q, ptr_nxt, top_idx, wr_idx;
  logic [W-1:0]  mem_q [DEPTH];

  assign top_idx = ptr_q - 1'b1;
  // pop first: a simultaneous push lands in the slot just vacated
  assign wr_idx  = pop ? top_idx : ptr_q;

  always_comb begin
    ptr_nxt = ptr_q;
    if (push && !pop)      ptr_nxt = ptr_q + 1'b1;
    else if (pop && !push) ptr_nxt = top_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_nxt;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = push && (wr_idx == PW'(i));
    always_ff @(posedge clk) begin
      if (slot_en) mem_q[i] <= wdata;
    end
  end

  assign top = mem_q[top_idx];

  // R6 / R9: whatever was pushed is the next value a return sees
  assert_push_on_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (top == $past(wdata)));

  // R9: push with pop keeps the depth, so a second push-with-pop hits the same slot
  assert_pair_keeps_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (top_idx == $past(top_idx)));
endmodule

// File: rtl/pcs_counter.sv
module pcs_counter
  import pcs_pkg::*;
#(
  parameter int unsigned PC_W   = 13,
  parameter int unsigned LO_W   = 8,
  parameter int unsigned HI_W   = 5,
  parameter int unsigned TGT_W  = 11,
  parameter int unsigned MEM_AW = 10,
  parameter int unsigned DEPTH  = 8,
  parameter logic [PC_W-1:0] VECTOR = 13'h0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              lo_we,
  input  logic [LO_W-1:0]   lo_din,
  input  logic              hi_we,
  input  logic [HI_W-1:0]   hi_din,
  input  logic              jump_req,
  input  logic              call_req,
  input  logic [TGT_W-1:0]  target,
  input  logic              irq_ack,
  input  logic              ret_req,
  output logic [PC_W-1:0]   fetch_addr,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              flush
);
  logic [1:0]      rst_sync_q;
  logic            rst_q_n;
  logic [PC_W-1:0] pc_q, pc_nxt, pop_top;
  logic [HI_W-1:0] latch_q, latch_nxt;
  logic            flush_q, redirect, push, pop;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  pcs_next #(
    .PC_W(PC_W), .LO_W(LO_W), .HI_W(HI_W), .TGT_W(TGT_W), .VECTOR(VECTOR)
  ) i_next (
    .pc_q(pc_q), .latch_q(latch_q), .step_en(step_en), .lo_we(lo_we),
    .lo_din(lo_din), .jump_req(jump_req), .call_req(call_req),
    .target(target), .irq_ack(irq_ack), .ret_req(ret_req),
    .pop_top(pop_top), .pc_nxt(pc_nxt), .redirect(redirect),
    .push(push), .pop(pop)
  );

  pcs_ret_stack #(.W(PC_W), .DEPTH(DEPTH)) i_stack (
    .clk(clk), .rst_n(rst_q_n), .push(push), .pop(pop),
    .wdata(pc_q), .top(pop_top)
  );

  assign latch_nxt = hi_we ? hi_din : latch_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pc_q    <= '0;
      latch_q <= '0;
      flush_q <= 1'b0;
    end else begin
      pc_q    <= pc_nxt;
      latch_q <= latch_nxt;
      flush_q <= redirect;
    end
  end

  assign fetch_addr = pc_q;
  assign mem_addr   = pc_q[MEM_AW-1:0];
  assign flush      = flush_q;

  // R2: a plain step adds exactly one
  assert_step_adds_one_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step_en && !redirect) |=> (fetch_addr == $past(fetch_addr) + 1'b1));

  // R2: nothing requested, nothing moves
  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!step_en && !redirect) |=> $stable(fetch_addr));

  // R5: acknowledge lands on the vector
  assert_vector_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_ack |=> (fetch_addr == VECTOR));

  // R4: opcode target reaches the low bits
  assert_target_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!irq_ack && (call_req || (jump_req && !ret_req)))
      |=> (fetch_addr[TGT_W-1:0] == $past(target)));

  // R6: a lone return takes the stack top
  assert_return_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ret_req && !irq_ack && !call_req) |=> (fetch_addr == $past(pop_top)));

  // R10: flush marks exactly the cycle after a redirect
  assert_flush_after_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (irq_ack || call_req || ret_req || jump_req || lo_we) |=> flush);
  assert_no_flush_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(irq_ack || call_req || ret_req || jump_req || lo_we) |=> !flush);

  // R12: the latch only follows its own write strobe
  assert_latch_stable_R12: assert property (@(posedge clk) disable iff (!rst_q_n)
    !hi_we |=> $stable(latch_q));
endmodule

// File: tb/test_pcs_counter.sv
module test_pcs_counter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_en, lo_we, hi_we, jump_req, call_req, irq_ack, ret_req;
  logic [7:0]  lo_din;
  logic [4:0]  hi_din;
  logic [10:0] target;
  logic [12:0] fetch_addr;
  logic [9:0]  mem_addr;
  logic        flush;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // reference model
  logic [12:0] m_pc;
  logic [4:0]  m_lat;
  logic [12:0] m_ring [8];
  logic [2:0]  m_ptr;
  logic        m_flush;

  always #2 clk = ~clk;   // 250 MHz

  pcs_counter i_pcs_counter (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .lo_we(lo_we),
    .lo_din(lo_din), .hi_we(hi_we), .hi_din(hi_din), .jump_req(jump_req),
    .call_req(call_req), .target(target), .irq_ack(irq_ack),
    .ret_req(ret_req), .fetch_addr(fetch_addr), .mem_addr(mem_addr),
    .flush(flush)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog R1: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input logic [12:0] act, input logic [12:0] exp,
                     input string tag, input string what);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    step_en = 0; lo_we = 0; hi_we = 0; jump_req = 0; call_req = 0;
    irq_ack = 0; ret_req = 0; lo_din = '0; hi_din = '0; target = '0;
  endtask

  // one cycle: drive at negedge, update model, sample after the edge
  task automatic step(input logic s, input logic l, input logic [7:0] ld,
                      input logic h, input logic [4:0] hd, input logic j,
                      input logic c, input logic [10:0] tg, input logic i,
                      input logic r, input string tag);
    logic [12:0] popv;
    @(negedge clk);
    step_en = s; lo_we = l; lo_din = ld; hi_we = h; hi_din = hd;
    jump_req = j; call_req = c; target = tg; irq_ack = i; ret_req = r;
    popv = '0;
    m_flush = i | c | r | j | l;
    if (r) begin m_ptr = m_ptr - 3'd1; popv = m_ring[m_ptr]; end
    if (i | c) begin m_ring[m_ptr] = m_pc; m_ptr = m_ptr + 3'd1; end
    if (i)      m_pc = 13'h0004;
    else if (c) m_pc = {m_lat[4:3], tg};
    else if (r) m_pc = popv;
    else if (j) m_pc = {m_lat[4:3], tg};
    else if (l) m_pc = {m_lat, ld};
    else if (s) m_pc = m_pc + 13'd1;
    if (h) m_lat = hd;
    @(posedge clk);
    #1;
    chk(fetch_addr, m_pc, tag, "fetch_addr");
    chk({3'b0, mem_addr}, {3'b0, m_pc[9:0]}, "R11", "mem_addr");
    chk({12'b0, flush}, {12'b0, m_flush}, "R10", "flush");
  endtask

  initial begin
    idle_inputs();
    m_pc = '0; m_lat = '0; m_ptr = '0; m_flush = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(fetch_addr, 13'h0000, "R1", "fetch_addr in reset");
    chk({12'b0, flush}, 13'h0, "R1", "flush in reset");
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    chk(fetch_addr, 13'h0000, "R1", "fetch_addr after release");
    chk({12'b0, flush}, 13'h0, "R1", "flush after release");

    // R2: hold, then steps
    step(0,0,8'h00,0,5'h00,0,0,11'h000,0,0,"R2");
    for (int k = 0; k < 3; k++) step(1,0,8'h00,0,5'h00,0,0,11'h000,0,0,"R2");

    // R12 latch write, R3 low-byte load to the top, R2 wrap, R11 wrapped address
    step(0,0,8'h00,1,5'h1F,0,0,11'h000,0,0,"R12");
    step(0,1,8'hFF,0,5'h00,0,0,11'h000,0,0,"R3");
    step(1,0,8'h00,0,5'h00,0,0,11'h000,0,0,"R2");
    // R3 uses the old latch when written in the same cycle
    step(0,1,8'h5A,1,5'h06,0,0,11'h000,0,0,"R3");
    step(0,1,8'hA5,0,5'h00,0,0,11'h000,0,0,"R3");

    // R4 jump keeps latch bits 4:3
    step(0,0,8'h00,1,5'h1B,0,0,11'h000,0,0,"R12");
    step(0,0,8'h00,0,5'h00,1,0,11'h155,0,0,"R4");
    // R5 interrupt vector, R6 return
    step(0,0,8'h00,0,5'h00,0,0,11'h000,1,0,"R5");
    step(1,0,8'h00,0,5'h00,0,0,11'h000,0,0,"R2");
    step(0,0,8'h00,0,5'h00,0,0,11'h000,0,1,"R6");

    // R7: nine calls then nine returns through the ring
    for (int k = 0; k < 9; k++) begin
      step(1,0,8'h00,0,5'h00,0,0,11'h000,0,0,"R2");
      step(0,0,8'h00,0,5'h00,0,1,11'(k * 97 + 3),0,0,"R7");
    end
    for (int k = 0; k < 9; k++) step(0,0,8'h00,0,5'h00,0,0,11'h000,0,1,"R7");
    // R12: latch untouched by all of that
    step(0,1,8'h3C,0,5'h00,0,0,11'h000,0,0,"R12");

    // R9: call and return together, then returns expose the ring
    step(0,0,8'h00,0,5'h00,0,1,11'h222,0,0,"R6");
    step(0,0,8'h00,0,5'h00,0,1,11'h333,0,0,"R6");
    step(0,0,8'h00,0,5'h00,0,1,11'h444,0,1,"R9");
    step(1,0,8'h00,0,5'h00,0,0,11'h000,0,0,"R9");
    step(0,0,8'h00,0,5'h00,0,0,11'h000,0,1,"R9");
    step(0,0,8'h00,0,5'h00,0,0,11'h000,0,1,"R9");
    step(0,0,8'h00,0,5'h00,0,0,11'h000,1,1,"R9");
    step(0,0,8'h00,0,5'h00,0,0,11'h000,0,1,"R9");

    // R8: priority samples
    step(1,1,8'h77,0,5'h00,0,0,11'h000,0,0,"R8");
    step(0,1,8'h11,0,5'h00,1,0,11'h0AA,0,0,"R8");
    step(0,0,8'h00,0,5'h00,1,0,11'h0BB,0,1,"R8");
    step(1,1,8'h22,0,5'h00,1,1,11'h0CC,1,1,"R8");

    // sweep over every request combination after filling the ring
    for (int k = 0; k < 8; k++) step(0,0,8'h00,0,5'h00,0,1,11'(k * 211 + 5),0,0,"R7");
    for (int rnd = 0; rnd < 4; rnd++) begin
      for (int code = 0; code < 128; code++) begin
        step(code[0], code[1], 8'(code * 37 + rnd), code[2], 5'(code ^ rnd),
             code[3], code[4], 11'(code * 113 + rnd * 517), code[5], code[6], "R8");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule